// File: doc/BRIEF.md
# Eight-Channel Audio Capture FIFO

This block gathers audio samples from eight input channels into one shared queue of 32-bit entries. The external per-channel receivers deliver each sample as a whole word with a one-cycle valid strobe. Each entry carries the number of the channel it came from in its three low bits. A small register window gives the host a control register, a status register and a data register. The control register holds the port enable, a DMA enable, a write-one-to-clear overflow bit and eight 3-bit serial format codes. The format codes drive the receivers directly.

The host empties the queue by reading the data register. Each read returns the oldest entry and removes it. A write to the data register injects a word into the input side of the queue, which lets software test the path without live audio. The word's low three bits name the channel it claims to come from. A DMA request stays raised while DMA is enabled and the queue holds data. Clearing the enable bit discards everything that is queued.

Top module: `audio_in_fifo`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, a data read returns 0, and dma_req is 0.
- R2: Register addresses are 0 for control, 1 for status and 2 for data; address 3 reads 0. A control write keeps bits 31:7 and bit 5. Bits 6 and 4:0 always read back as 0.
- R3: fmt_o carries the format code of channel i on bits 3i+2:3i, taken from control bits 8+3i+2:8+3i. The codes pass through unchanged: 000 left-justified pair, 001 I2S, 010/011 reserved, 100/101/110/111 right-justified 24/20/18/16 bit.
- R4: A sample on channel c is queued as {sample[28:0], c[2:0]}. When nothing contends, the word strobed at clock edge k is written at edge k+1.
- R5: When several channels hold words, one word is queued per cycle, lowest channel number first. Each channel keeps its word in a one-word holding register until it is taken.
- R6: While control bit 7 (enable) is 0, channel strobes are ignored and held words are not queued.
- R7: A control write that changes bit 7 from 1 to 0 empties both the queue and the holding registers at that edge.
- R8: While a data read is presented, reg_rdata shows the oldest entry, and the entry is removed at the clock edge. A data read on an empty queue returns 0 and changes nothing.
- R9: A data write queues the written word unchanged, whatever the enable bit is. In that cycle it takes priority over any held channel word.
- R10: A push that finds 8 entries already queued is dropped and sets the sticky overflow flag (status bit 0). The fill count is on status bits 11:8. A strobe on a channel whose holding register is still occupied and not being taken is also lost, and it also sets the flag.
- R11: Writing 1 to control bit 6 clears the overflow flag, unless a new overflow occurs in the same cycle.
- R12: dma_req is 1 exactly when control bit 5 is 1 and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_valid | input | 8 | Per-channel sample strobe |
| ch_data | input | 232 | Per-channel 29-bit samples, channel i at bits 29i+28:29i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when addressing data) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on address and state |
| fmt_o | output | 24 | Format codes for the eight receivers |
| dma_req | output | 1 | DMA request |

## Verification
Read data is combinational, so a data read shows the head entry in the same cycle. The pop, a host push and a control update appear from the following cycle onward. A channel strobe reaches the queue two register stages later: the first edge loads the holding register and the next edge writes the queue, so the fill count rises only in the cycle after that. The bench drives inputs on the falling edge and compares against its model shortly afterwards. It advances the model exactly once per rising edge, so every result is checked in the cycle it is due.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    localparam int NCH      = 8;
    localparam int TAG_W    = $clog2(NCH);
    localparam int WORD_W   = 32;
    localparam int SAMPLE_W = WORD_W - TAG_W;
    localparam int FMT_W    = 3;
    localparam int FMT_LSB  = 8;
    localparam int BIT_DMA  = 5;
    localparam int BIT_CLR  = 6;
    localparam int BIT_EN   = 7;
    localparam logic [WORD_W-1:0] CTRL_KEEP =
        ({WORD_W{1'b1}} << BIT_EN) | (WORD_W'(1) << BIT_DMA);

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/afifo_holds.sv
module afifo_holds #(
    parameter int NCH      = 8,
    parameter int SAMPLE_W = 29,
    parameter int TAG_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic                      flush,
    input  logic                      take,
    input  logic [NCH-1:0]            in_valid,
    input  logic [NCH*SAMPLE_W-1:0]   in_data,
    output logic                      offer_valid,
    output logic [SAMPLE_W+TAG_W-1:0] offer_entry,
    output logic                      lost
);
    typedef struct packed {
        logic [NCH-1:0]               occ;
        logic [NCH-1:0][SAMPLE_W-1:0] dat;
    } hold_t;

    hold_t s_d, s_q;
    logic [TAG_W-1:0] sel;
    logic             found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (s_q.occ[i] && !found) begin
                found = 1'b1;
                sel   = TAG_W'(i);
            end
        end
        offer_valid = found;
        offer_entry = {s_q.dat[sel], sel};

        s_d  = s_q;
        lost = 1'b0;
        if (take && found) s_d.occ[sel] = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (cap_en && in_valid[i]) begin
                if (s_q.occ[i] && !(take && found && sel == TAG_W'(i))) begin
                    lost = 1'b1;
                end else begin
                    s_d.occ[i] = 1'b1;
                    s_d.dat[i] = in_data[i*SAMPLE_W +: SAMPLE_W];
                end
            end
        end
        if (flush) begin
            s_d.occ = '0;
            lost    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } store_t;

    store_t s_d, s_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = push_data;
            s_d.wp          = bump(s_q.wp);
        end
        if (pop) s_d.rp = bump(s_q.rp);
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;
endmodule

// File: rtl/audio_in_fifo.sv
module audio_in_fifo
    import afifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          ch_valid,
    input  logic [NCH*SAMPLE_W-1:0] ch_data,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [1:0]              reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    output logic [NCH*FMT_W-1:0]    fmt_o,
    output logic                    dma_req
);
    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic              ovf;
    } top_t;

    top_t s_d, s_q;

    logic              wr_ctrl, wr_data, rd_pop, flush, take, full;
    logic              push_req, push_ok, drop, lost;
    logic              hold_valid;
    logic [WORD_W-1:0] hold_entry, push_word, head;
    logic [CW-1:0]     cnt;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(reg_addr);

    afifo_holds #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .TAG_W(TAG_W)) u_holds (
        .clk(clk), .rst_n(rst_n),
        .cap_en(s_q.ctrl[BIT_EN]), .flush(flush), .take(take),
        .in_valid(ch_valid), .in_data(ch_data),
        .offer_valid(hold_valid), .offer_entry(hold_entry), .lost(lost)
    );

    afifo_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push_ok), .push_data(push_word), .pop(rd_pop), .flush(flush),
        .head(head), .count(cnt)
    );

    always_comb begin
        wr_ctrl   = reg_wr && addr == RA_CTRL;
        wr_data   = reg_wr && addr == RA_DATA;
        flush     = wr_ctrl && s_q.ctrl[BIT_EN] && !reg_wdata[BIT_EN];
        full      = cnt == CW'(DEPTH);
        rd_pop    = reg_rd && !reg_wr && addr == RA_DATA && cnt != '0 && !flush;
        take      = hold_valid && !wr_data && s_q.ctrl[BIT_EN] && !flush;
        push_req  = wr_data || take;
        push_word = wr_data ? reg_wdata : hold_entry;
        push_ok   = push_req && !full && !flush;
        drop      = push_req && full && !flush;

        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = reg_wdata & CTRL_KEEP;
        if (drop || lost)                     s_d.ovf = 1'b1;
        else if (wr_ctrl && reg_wdata[BIT_CLR]) s_d.ovf = 1'b0;

        unique case (addr)
            RA_CTRL: reg_rdata = s_q.ctrl;
            RA_STAT: reg_rdata = (WORD_W'(cnt) << 8) | WORD_W'(s_q.ovf);
            RA_DATA: reg_rdata = (cnt != '0) ? head : '0;
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fmt_o   = s_q.ctrl[FMT_LSB +: NCH*FMT_W];
    assign dma_req = s_q.ctrl[BIT_DMA] && cnt != '0;
endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   ctrl_q,
    input logic          ovf_q,
    input logic [CW-1:0] cnt,
    input logic          dma_req
);
    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && ctrl_q[7] && !reg_wdata[7]) |=> cnt == '0);

    // R10
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && cnt == CW'(DEPTH)) |=> ovf_q);

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 2'd2 && cnt == '0 && !ctrl_q[7]) |=> cnt == '0);

    // R11
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[6] && !ctrl_q[7]) |=> !ovf_q);

    // R6
    disabled_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && !reg_wr) |=> cnt <= $past(cnt));

    // R12
    dma_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> cnt != '0);
endmodule

bind audio_in_fifo afifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl_q(s_q.ctrl),
    .ovf_q(s_q.ovf), .cnt(cnt), .dma_req(dma_req)
);

// File: tb/tb_audio_in_fifo.sv
module tb_audio_in_fifo;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   ch_valid = '0;
    logic [231:0] ch_data = '0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]   reg_addr = 2'd3;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [23:0]  fmt_o;
    logic         dma_req;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl = '0;
    bit          m_ovf = 1'b0;
    logic [31:0] q[$];
    bit          occ[8];
    logic [28:0] hv[8];

    always #10 clk = ~clk;

    audio_in_fifo dut (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic [31:0] er;
        bit wc, wd, rdp, fl, en, full, drop, lost;
        int pick;
        #1;
        case (reg_addr)
            2'd0: er = m_ctrl;
            2'd1: er = (32'(q.size()) << 8) | 32'(m_ovf);
            2'd2: er = (q.size() > 0) ? q[0] : 32'h0;
            default: er = 32'h0;
        endcase
        chk(tag, "rdata", reg_rdata, er);
        chk(tag, "dma_req", 32'(dma_req), 32'(m_ctrl[5] && q.size() > 0));
        chk("R3", "fmt_o", 32'(fmt_o), 32'(m_ctrl[31:8]));
        // model step
        wc = reg_wr && reg_addr == 2'd0;
        wd = reg_wr && reg_addr == 2'd2;
        en = m_ctrl[7];
        fl = wc && en && !reg_wdata[7];
        rdp = reg_rd && !reg_wr && reg_addr == 2'd2 && q.size() > 0 && !fl;
        full = q.size() == 8;
        pick = -1;
        if (en && !wd && !fl)
            for (int i = 7; i >= 0; i--) if (occ[i]) pick = i;
        drop = 0; lost = 0;
        if (rdp) void'(q.pop_front());
        if (wd || pick >= 0) begin
            if (full) drop = 1;
            else q.push_back(wd ? reg_wdata : {hv[pick], 3'(pick)});
        end
        if (pick >= 0) occ[pick] = 0;
        if (en && !fl)
            for (int i = 0; i < 8; i++)
                if (ch_valid[i]) begin
                    if (occ[i]) lost = 1;
                    else begin occ[i] = 1; hv[i] = ch_data[i*29 +: 29]; end
                end
        if (pick >= 0 && en && !fl && ch_valid[pick] && !occ[pick]) ;
        if (fl) begin
            q.delete();
            for (int i = 0; i < 8; i++) occ[i] = 0;
        end
        if (drop || lost) m_ovf = 1;
        else if (wc && reg_wdata[6]) m_ovf = 0;
        if (wc) m_ctrl = reg_wdata & 32'hFFFF_FFA0;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_addr = 2'd3; ch_valid = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick(tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        reg_rd = 1; reg_addr = a; tick(tag);
    endtask

    task automatic send(input logic [7:0] m, input int base, input string tag);
        ch_valid = m;
        for (int i = 0; i < 8; i++) ch_data[i*29 +: 29] = 29'(base + i * 29'h10101);
        tick(tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin occ[i] = 0; hv[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
        // R2 control write masking, R3 formats 0..7, R12 dma enable
        wr(2'd0, 32'hFAC6_88FF, "R2");
        rd(2'd0, "R2"); rd(2'd3, "R2");
        wr(2'd0, {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 8'hA0}, "R3");
        // R4 single channel
        send(8'h08, 29'h0ABCDE, "R4");
        rd(2'd1, "R4"); rd(2'd1, "R4"); rd(2'd2, "R4");
        // R5 simultaneous channels, lowest first
        send(8'hA5, 29'h100, "R5");
        rd(2'd1, "R5");
        for (int i = 0; i < 5; i++) rd(2'd2, "R5");
        // R8 empty read
        rd(2'd2, "R8"); rd(2'd1, "R8");
        // R9 host push beats a held word
        send(8'h02, 29'h777, "R9");
        wr(2'd2, 32'h1234_5677, "R9");
        rd(2'd2, "R9"); rd(2'd2, "R9"); rd(2'd1, "R9");
        // R10 overflow on full
        for (int i = 0; i < 10; i++) wr(2'd2, 32'hC000_0000 + 32'(i), "R10");
        rd(2'd1, "R10");
        send(8'h01, 29'h55, "R10"); send(8'h01, 29'h66, "R10");
        rd(2'd1, "R10");
        // R11 clear keeps enable
        rd(2'd2, "R11"); rd(2'd2, "R11"); rd(2'd2, "R11");
        wr(2'd0, 32'h0000_00E0, "R11");
        rd(2'd1, "R11");
        // R7 flush via enable fall
        send(8'h30, 29'h99, "R7");
        wr(2'd0, 32'h0000_0020, "R7");
        rd(2'd1, "R7"); rd(2'd2, "R7");
        // R6 disabled ignores channels
        send(8'hFF, 29'h4444, "R6"); send(8'hFF, 29'h4444, "R6");
        rd(2'd1, "R6");
        wr(2'd0, 32'h0000_0080, "R6");
        rd(2'd1, "R6");
        // R12 dma off with data queued
        wr(2'd2, 32'h0000_0003, "R12"); rd(2'd1, "R12");
        wr(2'd0, 32'h0000_00A0, "R12"); rd(2'd1, "R12");
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            ch_valid = 8'($urandom);
            for (int i = 0; i < 8; i++) ch_data[i*29 +: 29] = 29'($urandom);
            if (r < 45) begin reg_rd = 1; reg_addr = 2'd2; end
            else if (r < 55) begin reg_wr = 1; reg_addr = 2'd2; reg_wdata = $urandom; end
            else if (r < 58) begin reg_wr = 1; reg_addr = 2'd0; reg_wdata = $urandom | 32'h80; end
            else if (r < 60) begin reg_wr = 1; reg_addr = 2'd0; reg_wdata = $urandom & 32'hFFFF_FF7F; end
            else begin reg_addr = 2'($urandom); end
            tick("R5");
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule